// File: doc/BRIEF.md
# Descriptor-Ring DMA Register Bank

This block is the 32-bit register bank of an Ethernet DMA engine that serves eight transmit and eight receive descriptor rings. It decodes full-word accesses inside a 4 KB window. The byte address is divided by four to give the register index, and each register has one access policy: read-only, read-write, write-only or write-one-to-clear. Locations that hold no register read as zero, and writes to them have no effect.

The bank also carries the ring-related side effects. A write to a ring base register aligns the value to eight bytes and loads the ring's current pointer with the same value. The transmit and receive halt-status registers hold one halt flag per ring, and the descriptor walker sets these flags through dedicated inputs. When software clears a halt flag, the bank sends a one-cycle restart strobe to that ring. The two directions follow different rules for firing the strobe. The configuration word and the write-only command word drive the datapath directly.

Writes complete in a single cycle. Read data is registered and appears one cycle after the read request.

Top module: `ring_regbank`

## Requirements
- R1: The register index is addr_i[11:2], and addr_i[1:0] is ignored. An index that holds no register (for example byte address 0xFFC) reads as zero, and writes to it change nothing.
- R2: The identity word at 0x000 is read-only and always reads 0x0A55_0100. Writes to it are dropped and raise no error.
- R3: The configuration word at 0x004 is read-write with reset value 0x0000_0600. It reads back the last value written and drives cfg_o.
- R4: The command word at 0x008 is write-only. It always reads zero, and the last value written drives cmd_o.
- R5: The error-flag word at 0x00C is write-one-to-clear with reset value 0x0000_FFFF. Each 1 in the write data clears the matching bit, and each 0 leaves its bit unchanged.
- R6: Transmit ring base i is at 0x100+4i and receive ring base i is at 0x200+4i. A write stores the data with bits [2:0] forced to zero and loads the same value into that ring's pointer (transmit 0x180+4i, receive 0x280+4i). The pointers of other rings are left unchanged. All bases and pointers reset to zero.
- R7: Ring pointer registers are read-write. A direct write stores the data with bits [2:0] forced to zero.
- R8: In the transmit halt status at 0x010, bit 31-i is the halt flag of ring i, and bits 23:0 read zero. All flags are set at reset (0xFF00_0000). Writing 1 to a flag bit clears it and always fires tx_restart_o[i].
- R9: In the receive halt status at 0x014, bit 23-i is the halt flag of ring i, and the other bits read zero. Reset value is 0x00FF_0000. Writing 1 to a flag bit clears it, but fires rx_restart_o[i] only if that flag was already clear before the write.
- R10: A restart strobe is high for exactly the one cycle that follows the clock edge at which the write is taken. Several rings can strobe in the same cycle.
- R11: A 1 on tx_halt_set_i[i] or rx_halt_set_i[i] sets the matching halt flag. When a set and a software clear hit the same flag in the same cycle, the set wins, and the strobe rule still applies.
- R12: rdata_o is updated at the clock edge that takes a read and shows the state before any write at that edge. It holds its value otherwise and is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address inside the 4 KB window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| tx_halt_set_i | input | 8 | Per-ring transmit halt set from the walker |
| rx_halt_set_i | input | 8 | Per-ring receive halt set from the walker |
| tx_restart_o | output | 8 | One-cycle restart strobes, transmit rings |
| rx_restart_o | output | 8 | One-cycle restart strobes, receive rings |
| cfg_o | output | 32 | Configuration word |
| cmd_o | output | 32 | Last command word written |

## Verification
The assertions assume that req_i, we_i and addr_i are known at every sampled edge. They also assume that a strobe can come only from a write to the matching status index taken one edge earlier, so they check strobe origin and read-data holding against port history and need no model of the flags. The bench drives every input at the falling edge and issues at most one access per cycle. It raises the halt-set inputs only in cycles it controls, including one cycle that deliberately collides a set with a clear, so that every assumed input pattern stays legal.

// File: rtl/ring_regbank_pkg.sv
package ring_regbank_pkg;
  localparam int DW    = 32;
  localparam int AW    = 12;
  localparam int IDX_W = AW - 2;

  // register indices (byte address / 4)
  localparam logic [IDX_W-1:0] IDX_ID    = 10'h000;
  localparam logic [IDX_W-1:0] IDX_CFG   = 10'h001;
  localparam logic [IDX_W-1:0] IDX_CMD   = 10'h002;
  localparam logic [IDX_W-1:0] IDX_ERR   = 10'h003;
  localparam logic [IDX_W-1:0] IDX_TXS   = 10'h004;
  localparam logic [IDX_W-1:0] IDX_RXS   = 10'h005;
  localparam logic [IDX_W-1:0] IDX_TXB   = 10'h040;
  localparam logic [IDX_W-1:0] IDX_TXP   = 10'h060;
  localparam logic [IDX_W-1:0] IDX_RXB   = 10'h080;
  localparam logic [IDX_W-1:0] IDX_RXP   = 10'h0A0;

  typedef enum logic [1:0] {POL_RO, POL_RW, POL_WO, POL_W1C} pol_e;
endpackage

// File: rtl/regbank_ring_file.sv
module regbank_ring_file #(
  parameter int N     = 8,
  parameter int DW    = 32,
  parameter int IDX_W = 10,
  parameter int ALIGN = 3,
  parameter logic [IDX_W-1:0] BASE_IDX = '0,
  parameter logic [IDX_W-1:0] PTR_IDX  = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [N-1:0][DW-1:0] base_o,
  output logic [N-1:0][DW-1:0] ptr_o
);
  localparam int RB = $clog2(N);

  logic          base_hit, ptr_hit;
  logic [DW-1:0] wdata_al;
  logic          unused_lsb;

  assign base_hit   = wr_i && (idx_i[IDX_W-1:RB] == BASE_IDX[IDX_W-1:RB]);
  assign ptr_hit    = wr_i && (idx_i[IDX_W-1:RB] == PTR_IDX[IDX_W-1:RB]);
  assign wdata_al   = {wdata_i[DW-1:ALIGN], {ALIGN{1'b0}}};
  assign unused_lsb = ^wdata_i[ALIGN-1:0];

  for (genvar g = 0; g < N; g++) begin : g_ring
    logic sel;
    assign sel = (idx_i[RB-1:0] == RB'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[g] <= '0;
        ptr_o[g]  <= '0;
      end else if (base_hit && sel) begin
        base_o[g] <= wdata_al;
        ptr_o[g]  <= wdata_al;     // shadow load of the ring pointer
      end else if (ptr_hit && sel) begin
        ptr_o[g]  <= wdata_al;
      end
    end
  end
endmodule

// File: rtl/regbank_halt.sv
module regbank_halt #(
  parameter int N       = 8,
  parameter int DW      = 32,
  parameter int TOP     = 31,
  parameter bit RX_RULE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [N-1:0]  set_i,
  output logic [DW-1:0] stat_o,
  output logic [N-1:0]  strobe_o
);
  logic [N-1:0] flag_q, clr, fire;
  logic         unused_w;

  assign unused_w = ^wdata_i;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      clr[i]  = wr_i && wdata_i[TOP-i];
      // receive rings restart only when the flag was already clear
      fire[i] = RX_RULE ? (clr[i] && !flag_q[i]) : clr[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= '1;
      strobe_o <= '0;
    end else begin
      flag_q   <= set_i | (flag_q & ~clr);
      strobe_o <= fire;
    end
  end

  always_comb begin
    stat_o = '0;
    for (int i = 0; i < N; i++) stat_o[TOP-i] = flag_q[i];
  end
endmodule

// File: rtl/ring_regbank.sv
module ring_regbank
  import ring_regbank_pkg::*;
#(
  parameter int          N_RINGS   = 8,
  parameter logic [31:0] ID_VALUE  = 32'h0A55_0100,
  parameter logic [31:0] CFG_RST   = 32'h0000_0600,
  parameter logic [31:0] ERR_RST   = 32'h0000_FFFF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [N_RINGS-1:0] tx_halt_set_i,
  input  logic [N_RINGS-1:0] rx_halt_set_i,
  output logic [N_RINGS-1:0] tx_restart_o,
  output logic [N_RINGS-1:0] rx_restart_o,
  output logic [DW-1:0]      cfg_o,
  output logic [DW-1:0]      cmd_o
);
  localparam int RB = $clog2(N_RINGS);

  logic [IDX_W-1:0]          idx;
  logic                      wr, unused_byte;
  pol_e                      pol;
  logic                      misc_hit;
  logic [DW-1:0]             err_q, rd;
  logic [DW-1:0]             txs, rxs;
  logic [N_RINGS-1:0][DW-1:0] txb, txp, rxb, rxp;

  assign idx         = addr_i[AW-1:2];
  assign unused_byte = ^addr_i[1:0];
  assign wr          = req_i && we_i;

  // policy of the scalar registers
  always_comb begin
    misc_hit = 1'b1;
    unique case (idx)
      IDX_ID:  pol = POL_RO;
      IDX_CFG: pol = POL_RW;
      IDX_CMD: pol = POL_WO;
      IDX_ERR: pol = POL_W1C;
      default: begin pol = POL_RO; misc_hit = 1'b0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= CFG_RST;
      cmd_o <= '0;
      err_q <= ERR_RST;
    end else if (wr && misc_hit) begin
      if (pol == POL_RW)  cfg_o <= wdata_i;
      if (pol == POL_WO)  cmd_o <= wdata_i;
      if (pol == POL_W1C) err_q <= err_q & ~wdata_i;
    end
  end

  regbank_ring_file #(
    .N(N_RINGS), .DW(DW), .IDX_W(IDX_W), .ALIGN(3),
    .BASE_IDX(IDX_TXB), .PTR_IDX(IDX_TXP)
  ) u_tx_rings (
    .clk_i, .rst_ni, .wr_i(wr), .idx_i(idx), .wdata_i,
    .base_o(txb), .ptr_o(txp)
  );

  regbank_ring_file #(
    .N(N_RINGS), .DW(DW), .IDX_W(IDX_W), .ALIGN(3),
    .BASE_IDX(IDX_RXB), .PTR_IDX(IDX_RXP)
  ) u_rx_rings (
    .clk_i, .rst_ni, .wr_i(wr), .idx_i(idx), .wdata_i,
    .base_o(rxb), .ptr_o(rxp)
  );

  regbank_halt #(.N(N_RINGS), .DW(DW), .TOP(31), .RX_RULE(1'b0)) u_tx_halt (
    .clk_i, .rst_ni, .wr_i(wr && idx == IDX_TXS), .wdata_i,
    .set_i(tx_halt_set_i), .stat_o(txs), .strobe_o(tx_restart_o)
  );

  regbank_halt #(.N(N_RINGS), .DW(DW), .TOP(23), .RX_RULE(1'b1)) u_rx_halt (
    .clk_i, .rst_ni, .wr_i(wr && idx == IDX_RXS), .wdata_i,
    .set_i(rx_halt_set_i), .stat_o(rxs), .strobe_o(rx_restart_o)
  );

  always_comb begin
    rd = '0;
    if      (idx == IDX_ID)  rd = ID_VALUE;
    else if (idx == IDX_CFG) rd = cfg_o;
    else if (idx == IDX_ERR) rd = err_q;
    else if (idx == IDX_TXS) rd = txs;
    else if (idx == IDX_RXS) rd = rxs;
    else if (idx[IDX_W-1:RB] == IDX_TXB[IDX_W-1:RB]) rd = txb[idx[RB-1:0]];
    else if (idx[IDX_W-1:RB] == IDX_TXP[IDX_W-1:RB]) rd = txp[idx[RB-1:0]];
    else if (idx[IDX_W-1:RB] == IDX_RXB[IDX_W-1:RB]) rd = rxb[idx[RB-1:0]];
    else if (idx[IDX_W-1:RB] == IDX_RXP[IDX_W-1:RB]) rd = rxp[idx[RB-1:0]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_o <= '0;
    else if (req_i && !we_i)   rdata_o <= rd;
  end
endmodule

// File: rtl/ring_regbank_chk.sv
module ring_regbank_chk
  import ring_regbank_pkg::*;
#(
  parameter int          N_RINGS  = 8,
  parameter logic [31:0] ID_VALUE = 32'h0A55_0100
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [AW-1:0]      addr_i,
  input logic [DW-1:0]      rdata_o,
  input logic [N_RINGS-1:0] tx_restart_o,
  input logic [N_RINGS-1:0] rx_restart_o
);
  logic [IDX_W-1:0] idx;
  logic             rd_req;
  assign idx    = addr_i[AW-1:2];
  assign rd_req = req_i && !we_i;

  a_r1_undef_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && idx == '1) |=> (rdata_o == '0));

  a_r2_id_constant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && idx == IDX_ID) |=> (rdata_o == ID_VALUE));

  a_r4_cmd_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && idx == IDX_CMD) |=> (rdata_o == '0));

  a_r8_tx_strobe_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tx_restart_o) |-> $past(req_i && we_i && idx == IDX_TXS));

  a_r9_rx_strobe_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rx_restart_o) |-> $past(req_i && we_i && idx == IDX_RXS));

  a_r12_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_req) |-> $stable(rdata_o));
endmodule

bind ring_regbank ring_regbank_chk #(.N_RINGS(N_RINGS), .ID_VALUE(ID_VALUE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .tx_restart_o(tx_restart_o), .rx_restart_o(rx_restart_o)
);

// File: tb/ring_regbank_tb.sv
module ring_regbank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  logic        clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o, cfg_o, cmd_o;
  logic [7:0]  tx_halt_set_i = '0, rx_halt_set_i = '0, tx_restart_o, rx_restart_o;
  logic [7:0]  tx_seen, rx_seen;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ring_regbank u_dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .tx_halt_set_i, .rx_halt_set_i, .tx_restart_o, .rx_restart_o, .cfg_o, .cmd_o
  );

  // {write, addr, data-or-expected}
  localparam logic [44:0] VECS [NV] = '{
    {1'b0, 12'h000, 32'h0A55_0100},  // R2 id
    {1'b1, 12'h000, 32'hFFFF_FFFF},  // R2 write dropped
    {1'b0, 12'h000, 32'h0A55_0100},  // R2
    {1'b0, 12'h004, 32'h0000_0600},  // R3 reset
    {1'b1, 12'h004, 32'h1234_5678},
    {1'b0, 12'h004, 32'h1234_5678},  // R3
    {1'b1, 12'h008, 32'hCAFE_BABE},
    {1'b0, 12'h008, 32'h0000_0000},  // R4
    {1'b0, 12'h00C, 32'h0000_FFFF},  // R5 reset
    {1'b1, 12'h00C, 32'h0000_F00F},
    {1'b0, 12'h00C, 32'h0000_0FF0},  // R5
    {1'b1, 12'h00C, 32'h0000_0000},
    {1'b0, 12'h00C, 32'h0000_0FF0},  // R5 zeros keep
    {1'b1, 12'h104, 32'h1000_00FF},
    {1'b0, 12'h104, 32'h1000_00F8},  // R6 base aligned
    {1'b0, 12'h184, 32'h1000_00F8},  // R6 pointer shadow
    {1'b0, 12'h180, 32'h0000_0000},  // R6 other ring untouched
    {1'b1, 12'h21C, 32'hABCD_0007},
    {1'b0, 12'h29C, 32'hABCD_0000},  // R6 rx
    {1'b1, 12'h284, 32'h0000_0013},
    {1'b0, 12'h284, 32'h0000_0010},  // R7
    {1'b0, 12'h204, 32'h0000_0000},  // R7 base untouched
    {1'b1, 12'hFFC, 32'hFFFF_FFFF},
    {1'b0, 12'hFFC, 32'h0000_0000},  // R1 undefined
    {1'b0, 12'h010, 32'hFF00_0000},  // R8 reset
    {1'b0, 12'h014, 32'h00FF_0000}   // R9 reset
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    tx_halt_set_i = '0; rx_halt_set_i = '0;
    tx_seen = tx_restart_o; rx_seen = rx_restart_o;
  endtask

  task automatic idle_strobes_low(input string req);
    @(posedge clk_i); @(negedge clk_i);
    check(req, {16'h0, tx_restart_o, rx_restart_o}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL R12 watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R12 rdata reset", rdata_o, 32'h0);
    check("R10 strobes reset", {16'h0, tx_restart_o, rx_restart_o}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      access(VECS[v][44], VECS[v][43:32], VECS[v][31:0]);
      if (!VECS[v][44]) check($sformatf("vector %0d", v), rdata_o, VECS[v][31:0]);
    end
    check("R4 cmd_o", cmd_o, 32'hCAFE_BABE);
    check("R3 cfg_o", cfg_o, 32'h1234_5678);

    // R1 byte offset ignored
    access(1'b0, 12'h006, 32'h0);
    check("R1 byte offset", rdata_o, 32'h1234_5678);

    // R8 R10 two transmit rings strobe together
    access(1'b1, 12'h010, 32'hA000_0000);
    check("R10 tx multi strobe", {24'h0, tx_seen}, 32'h05);
    idle_strobes_low("R10 strobe one cycle");
    access(1'b0, 12'h010, 32'h0);
    check("R8 tx flags cleared", rdata_o, 32'h5F00_0000);
    // R8 already-clear flag still strobes
    access(1'b1, 12'h010, 32'h8000_0000);
    check("R8 tx strobe on clear flag", {24'h0, tx_seen}, 32'h01);
    // R11 set wins over clear, strobe still fires
    tx_halt_set_i = 8'h01;
    access(1'b1, 12'h010, 32'h8000_0000);
    check("R11 tx strobe with set", {24'h0, tx_seen}, 32'h01);
    access(1'b0, 12'h010, 32'h0);
    check("R11 set wins", rdata_o, 32'hDF00_0000);
    access(1'b1, 12'h010, 32'hFFFF_FFFF);
    check("R10 tx all strobe", {24'h0, tx_seen}, 32'hFF);
    access(1'b0, 12'h010, 32'h0);
    check("R8 tx all clear", rdata_o, 32'h0);

    // R9 set flag: clear without strobe
    access(1'b1, 12'h014, 32'h0080_0000);
    check("R9 rx no strobe on set flag", {24'h0, rx_seen}, 32'h00);
    access(1'b0, 12'h014, 32'h0);
    check("R9 rx flag cleared", rdata_o, 32'h007F_0000);
    access(1'b1, 12'h014, 32'h00C0_0000);
    check("R9 rx strobe only ring0", {24'h0, rx_seen}, 32'h01);
    idle_strobes_low("R10 rx strobe one cycle");
    access(1'b0, 12'h014, 32'h0);
    check("R9 rx flags", rdata_o, 32'h003F_0000);
    // R11 walker sets a receive flag
    rx_halt_set_i = 8'h01;
    @(posedge clk_i); @(negedge clk_i);
    rx_halt_set_i = '0;
    access(1'b0, 12'h014, 32'h0);
    check("R11 rx halt set", rdata_o, 32'h00BF_0000);

    // R12 read shows state before same-edge write, then holds
    access(1'b0, 12'h004, 32'h0);
    access(1'b1, 12'h004, 32'h0000_0001);
    check("R12 rdata holds over write", rdata_o, 32'h1234_5678);

    // reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R12 rdata after reset", rdata_o, 32'h0);
    access(1'b0, 12'h004, 32'h0);
    check("R3 cfg reset again", rdata_o, 32'h0000_0600);
    access(1'b0, 12'h184, 32'h0);
    check("R6 pointer reset", rdata_o, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule